// File: doc/BRIEF.md
# Sliding-Window Command Rate Limiter

This block keeps a stream of commands, such as DRAM row activates, from placing more than a set number of commands (four by default) inside any sliding window of `TFAW` clock cycles. The issuer pulses `cmd_valid_i` high for one cycle for each command it sends. The block records every pulse in a history shift register that is `TFAW` bits long. Each cycle it adds up the recorded commands and the command on the input in that cycle. When the total reaches the limit, the registered output `cmd_ready_o` goes low in the next cycle. It goes high again once the oldest of those commands has aged out of the window.

Back-pressure works as follows. `cmd_ready_o` is advice to the issuer: while it is low, the issuer must hold back new commands. The block does not gate `cmd_valid_i`. A pulse that arrives while ready is low is still recorded and counted, so a misbehaving issuer keeps ready low for longer and never corrupts the history. There is no buffering and no handshake on data. Cycles are counted from the first cycle after reset is released, which is cycle 0. The window for a given cycle is measured back from the cycle before it.

Top module: `faw_limiter`

## Requirements
- R1: In the cycle after any cycle in which `rst` is sampled high, `cmd_ready_o` is 1 and the history holds no commands.
- R2: `cmd_ready_o` is 0 in cycle n exactly when at least `MAX_CMDS` cycles among cycles n-1-`TFAW` through n-1 had `cmd_valid_i` = 1. Otherwise it is 1.
- R3: With `TFAW`=8, commands in cycles 1, 2, 3 and 4 make ready low in cycles 5 to 10 and high in cycles 0 to 4 and from cycle 11.
- R4: With `TFAW`=8, commands in cycles 1, 3, 5 and 7 keep ready high through cycle 7, make it low in cycles 8 to 10, and leave it high from cycle 11.
- R5: With `TFAW`=8, commands in cycles 1, 3, 7 and 9 make ready low in cycle 10 only.
- R6: With `TFAW`=8, commands in cycles 1, 3, 8 and 10 leave ready high in every cycle.
- R7: `cmd_ready_o` goes from 1 to 0 only in a cycle whose previous cycle had `cmd_valid_i` = 1.
- R8: `cmd_ready_o` goes from 0 to 1 only in a cycle whose previous cycle had `cmd_valid_i` = 0.
- R9: Commands that arrive while `cmd_ready_o` is 0 are recorded and counted. With a pulse in every cycle from cycle 1, ready is low from cycle 5 onward.
- R10: A reset asserted while ready is low clears the history. A single later command then leaves ready high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid_i | input | 1 | High for one cycle for each command issued |
| cmd_ready_o | output | 1 | Registered; high when another command may be issued |

## Verification
The bench builds the block with `TFAW`=8 and `MAX_CMDS`=4. These values make the four fixed command patterns directly comparable with their known ready traces. They also let a sweep stream every 12-bit command pattern, 4096 of them back to back, past the window. That covers every occupancy of the nine-cycle span that decides ready, including the edges where a command just enters or just leaves it. A bench-side bit history gives the expected ready each cycle, and rise and fall edges are checked against the previous cycle's input.

// File: rtl/fawl_pkg.sv
`timescale 1ns/1ps
package fawl_pkg;
  // Width needed to hold a count of up to n history bits plus the current input.
  function automatic int unsigned total_width(int unsigned n);
    return $clog2(n + 2);
  endfunction
endpackage

// File: rtl/fawl_history.sv
`timescale 1ns/1ps
module fawl_history #(
  parameter int unsigned DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_i,
  output logic [DEPTH-1:0] hist_o
);
  logic [DEPTH-1:0] hist_q;

  generate
    if (DEPTH == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) hist_q <= '0;
        else     hist_q <= push_i;
      end
    end else begin : g_shift
      always_ff @(posedge clk) begin
        if (rst) hist_q <= '0;
        else     hist_q <= {hist_q[DEPTH-2:0], push_i};
      end
    end
  endgenerate

  assign hist_o = hist_q;

  // R2: every sampled command enters the newest history slot
  assert_cmd_recorded_R2: assert property (@(posedge clk) disable iff (rst)
    push_i |=> hist_q[0]);

  // R1: reset empties the history
  assert_hist_cleared_R1: assert property (@(posedge clk)
    rst |=> (hist_q == '0));
endmodule

// File: rtl/fawl_popcount.sv
`timescale 1ns/1ps
module fawl_popcount #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned CW    = 4
) (
  input  logic [WIDTH-1:0] bits_i,
  input  logic             extra_i,
  output logic [CW-1:0]    total_o
);
  always_comb begin
    total_o = CW'(extra_i);
    for (int unsigned i = 0; i < WIDTH; i++) begin
      total_o = total_o + CW'(bits_i[i]);
    end
  end
endmodule

// File: rtl/fawl_gate.sv
`timescale 1ns/1ps
module fawl_gate #(
  parameter int unsigned CW    = 4,
  parameter int unsigned LIMIT = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] total_i,
  output logic          ready_o
);
  localparam logic [CW:0] LIMIT_W = (CW+1)'(LIMIT);

  logic ready_q;

  always_ff @(posedge clk) begin
    if (rst) ready_q <= 1'b1;
    else     ready_q <= ({1'b0, total_i} < LIMIT_W);
  end

  assign ready_o = ready_q;

  // R1: ready comes out of reset high
  assert_ready_after_reset_R1: assert property (@(posedge clk)
    rst |=> ready_q);
endmodule

// File: rtl/faw_limiter.sv
`timescale 1ns/1ps
module faw_limiter #(
  parameter int unsigned TFAW     = 8,
  parameter int unsigned MAX_CMDS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic cmd_valid_i,
  output logic cmd_ready_o
);
  localparam int unsigned CW = fawl_pkg::total_width(TFAW);

  logic [TFAW-1:0] hist;
  logic [CW-1:0]   total;

  fawl_history #(.DEPTH(TFAW)) u_hist (
    .clk    (clk),
    .rst    (rst),
    .push_i (cmd_valid_i),
    .hist_o (hist)
  );

  fawl_popcount #(.WIDTH(TFAW), .CW(CW)) u_count (
    .bits_i  (hist),
    .extra_i (cmd_valid_i),
    .total_o (total)
  );

  fawl_gate #(.CW(CW), .LIMIT(MAX_CMDS)) u_gate (
    .clk     (clk),
    .rst     (rst),
    .total_i (total),
    .ready_o (cmd_ready_o)
  );

  // R7: a new stall only follows an issued command
  assert_fall_after_cmd_R7: assert property (@(posedge clk) disable iff (rst)
    ($fell(cmd_ready_o) && $past(!rst)) |-> $past(cmd_valid_i));

  // R8: a stall only ends after an idle cycle
  assert_rise_after_idle_R8: assert property (@(posedge clk) disable iff (rst)
    ($rose(cmd_ready_o) && $past(!rst)) |-> !$past(cmd_valid_i));
endmodule

// File: tb/tb_faw_limiter.sv
`timescale 1ns/1ps
module tb_faw_limiter;
  localparam int T = 8;
  localparam int M = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic v   = 1'b0;
  logic ready;

  always #5 clk = ~clk;

  faw_limiter #(.TFAW(T), .MAX_CMDS(M)) dut (
    .clk         (clk),
    .rst         (rst),
    .cmd_valid_i (v),
    .cmd_ready_o (ready)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [63:0] bm = '0;
  logic prev_rdy = 1'b1;
  logic prev_v = 1'b0;
  bit have_prev = 0;

  task automatic chk(logic got, logic exp, string tag);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic model_ready();
    int c = 0;
    for (int i = 0; i <= T; i++) c += int'(bm[i]);
    return (c < M);
  endfunction

  // Called at a falling edge: checks the current cycle, then drives its input.
  task automatic sample_drive(logic nv, string tag);
    chk(ready, model_ready(), tag);
    if (have_prev && prev_rdy && !ready) chk(prev_v, 1'b1, "R7 fall needs prior command");
    if (have_prev && !prev_rdy && ready) chk(prev_v, 1'b0, "R8 rise needs prior idle");
    prev_rdy  = ready;
    prev_v    = nv;
    have_prev = 1;
    v  = nv;
    bm = {bm[62:0], nv};
  endtask

  task automatic do_reset(string tag);
    @(negedge clk);
    rst = 1'b1;
    v   = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    bm  = '0;
    have_prev = 0;
    chk(ready, 1'b1, tag);
  endtask

  task automatic scenario(logic [15:0] cmds, logic [15:0] lows, string tag);
    do_reset({tag, " R1 reset"});
    for (int n = 1; n < 16; n++) begin
      @(negedge clk);
      chk(ready, !lows[n], tag);
      sample_drive(cmds[n], {tag, " R2 model"});
    end
    @(negedge clk);
    v = 1'b0;
  endtask

  initial begin
    #1500000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    do_reset("R1 initial reset");

    scenario(16'h001E, 16'h07E0, "R3 burst");
    scenario(16'h00AA, 16'h0700, "R4 alternate");
    scenario(16'h028A, 16'h0400, "R5 one-cycle stall");
    scenario(16'h050A, 16'h0000, "R6 never four");

    // R2: every 12-bit pattern streamed back to back
    do_reset("R1 before sweep");
    for (int p = 0; p < 4096; p++) begin
      for (int b = 0; b < 12; b++) begin
        @(negedge clk);
        sample_drive(p[b], "R2 sweep");
      end
    end

    // R9: pulses keep arriving while ready is low
    do_reset("R1 before flood");
    for (int n = 1; n < 21; n++) begin
      @(negedge clk);
      chk(ready, (n < 5), "R9 flood");
      sample_drive(1'b1, "R9 flood model");
    end

    // R10: reset while stalled, then one command
    do_reset("R10 reset while low");
    for (int n = 1; n < 14; n++) begin
      @(negedge clk);
      chk(ready, 1'b1, "R10 after reset");
      sample_drive((n == 2), "R10 model");
    end

    @(negedge clk);
    v = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule